// File: doc/BRIEF.md
# Serial Audio Converter Byte Streamer

This block sits between a two-channel 24-bit delta-sigma audio converter and the write side of a parallel 8-bit USB FIFO. The converter's bit clock, channel-select word clock and serial data are brought into the system clock domain. Each bit is sampled on a bit-clock rising edge, and the bits are packed into bytes that are written to the FIFO whenever it has room.

The byte stream carries no framing bytes. Alignment comes from the restart rule. After reset, or after any byte arrives from the host, the block stays silent until the word clock rises. The first bit of a left word is then also the first bit of a byte. A host can therefore cut the stream into groups of six bytes: the left sample first, then the right sample, each sent most significant byte first in unchanged two's complement form.

Only the first 24 bits after each word-clock transition are kept, so converters with wider slots still give exactly three bytes per channel. If a byte is ready while the FIFO reports full, that byte is lost and a sticky overflow flag is raised. The next restart clears the flag.

Top module: `audio_adc_fifo_bridge`

## Requirements
- R1: While reset is applied and after it is released, `fifo_wr_o` and `overflow_o` are 0 and `fifo_data_o` is 0x00 until the first byte is written.
- R2: Serial data is sampled on the rising edge of the bit clock, and the first bit of each sample is its most significant bit.
- R3: After reset or a restart, no byte is written until the word clock has been sampled low and then high on bit-clock rising edges. Word clock high marks the left channel.
- R4: The output carries six bytes per stereo frame: left bits 23:16, 15:8, 7:0, then right bits 23:16, 15:8, 7:0. There are no extra bytes, and the sample values are passed through unchanged.
- R5: Only the first SAMPLE_BITS bits after each word-clock transition are captured. Any later bits in the same slot have no effect on the output.
- R6: `fifo_wr_o` is a single-cycle pulse per byte. It is asserted only in a cycle following a clock edge at which `fifo_full_i` was 0.
- R7: A byte that completes while `fifo_full_i` is 1 is discarded, and `overflow_o` goes to 1 and stays there until a restart. Byte alignment is kept across the dropped bytes.
- R8: A one-cycle pulse on `host_rx_i` clears `overflow_o`, discards any partially assembled byte, and returns the block to the waiting state of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk_i | input | 1 | Converter bit clock (asynchronous) |
| word_clk_i | input | 1 | Converter channel select, high = left (asynchronous) |
| ser_data_i | input | 1 | Converter serial data, changes on bit-clock falling edge |
| host_rx_i | input | 1 | High for one cycle when a byte arrives from the host; restarts alignment |
| fifo_full_i | input | 1 | FIFO transmit-full flag |
| fifo_data_o | output | 8 | Byte presented to the FIFO |
| fifo_wr_o | output | 1 | FIFO write strobe |
| overflow_o | output | 1 | Sticky flag: a byte was dropped while the FIFO was full |

## Verification
The bench builds the block with its default parameters: 24-bit samples, 8-bit bytes and two synchroniser stages. It drives a converter model with 32-bit slots and a bit clock eight system cycles long. The spare slot bits are driven to ones, so the slot-truncation rule is tested on every word. The model's left channel counts up across 0x7FFFFF and its right channel counts down across zero, which brings sign wrap into the byte ordering checks. Further sequences exercise a frame sent while the FIFO is full and a restart in the middle of a left word.

// File: rtl/adcb_pkg.sv
package adcb_pkg;

    typedef enum logic [0:0] {
        ALN_WAIT = 1'b0,
        ALN_RUN  = 1'b1
    } align_state_e;

    // Synchronised converter pins, in this bit order.
    typedef struct packed {
        logic bit_clk;
        logic word_clk;
        logic data;
    } serial_pins_t;

    // One event per bit-clock rising edge seen in the system domain.
    typedef struct packed {
        logic strobe;
        logic word_clk;
        logic data;
    } serial_evt_t;

    function automatic logic rose(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

endpackage

// File: rtl/adcb_sync.sv
module adcb_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= async_i;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/adcb_sampler.sv
module adcb_sampler
    import adcb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_clk_i,
    input  logic        word_clk_i,
    input  logic        ser_data_i,
    output serial_evt_t evt_o
);
    localparam int PIN_W = $bits(serial_pins_t);

    serial_pins_t pins_s;
    logic         bclk_prev_q;

    adcb_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i({bit_clk_i, word_clk_i, ser_data_i}),
        .sync_o (pins_s)
    );

    always_ff @(posedge clk) begin
        if (rst) bclk_prev_q <= 1'b0;
        else     bclk_prev_q <= pins_s.bit_clk;
    end

    always_comb begin
        evt_o.strobe   = rose(pins_s.bit_clk, bclk_prev_q);
        evt_o.word_clk = pins_s.word_clk;
        evt_o.data     = pins_s.data;
    end

    // R2: a sampling event never repeats on consecutive cycles
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
        evt_o.strobe |=> !evt_o.strobe);
endmodule

// File: rtl/adcb_framer.sv
module adcb_framer
    import adcb_pkg::*;
#(
    parameter int SAMPLE_BITS = 24,
    parameter int BYTE_BITS   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 restart_i,
    input  serial_evt_t          evt_i,
    output logic                 byte_vld_o,
    output logic [BYTE_BITS-1:0] byte_o
);
    localparam int CNT_W = $clog2(SAMPLE_BITS + 1);
    localparam int POS_W = (BYTE_BITS > 2) ? $clog2(BYTE_BITS) : 1;

    align_state_e         state_q;
    logic                 seen_low_q, prev_lr_q;
    logic [CNT_W-1:0]     slot_cnt_q;
    logic [POS_W-1:0]     pos_q, pos_eff;
    logic [BYTE_BITS-1:0] shreg_q, shifted;
    logic                 start_now, new_chan, take, last_bit;

    always_comb begin
        start_now = (state_q == ALN_WAIT) && evt_i.strobe && evt_i.word_clk && seen_low_q;
        new_chan  = (state_q == ALN_RUN) && evt_i.strobe && (evt_i.word_clk != prev_lr_q);
        take      = start_now || new_chan ||
                    ((state_q == ALN_RUN) && evt_i.strobe && (slot_cnt_q < CNT_W'(SAMPLE_BITS)));
        pos_eff   = (start_now || new_chan) ? '0 : pos_q;
        last_bit  = (pos_eff == POS_W'(BYTE_BITS - 1));
        shifted   = {shreg_q[BYTE_BITS-2:0], evt_i.data};
    end

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            state_q    <= ALN_WAIT;
            seen_low_q <= 1'b0;
            prev_lr_q  <= 1'b0;
            slot_cnt_q <= '0;
            pos_q      <= '0;
            shreg_q    <= '0;
            byte_vld_o <= 1'b0;
            byte_o     <= '0;
        end else begin
            byte_vld_o <= 1'b0;
            if (evt_i.strobe) begin
                prev_lr_q <= evt_i.word_clk;
                if (!evt_i.word_clk) seen_low_q <= 1'b1;
            end
            if (start_now) state_q <= ALN_RUN;
            if (take) begin
                shreg_q    <= shifted;
                slot_cnt_q <= (start_now || new_chan) ? CNT_W'(1) : slot_cnt_q + CNT_W'(1);
                pos_q      <= last_bit ? '0 : pos_eff + POS_W'(1);
                if (last_bit) begin
                    byte_vld_o <= 1'b1;
                    byte_o     <= shifted;
                end
            end
        end
    end

    // R5: capture never runs past the sample length inside one slot
    assert_slot_limit_R5: assert property (@(posedge clk) disable iff (rst)
        slot_cnt_q <= CNT_W'(SAMPLE_BITS));
    // R3: nothing is produced while still waiting for alignment
    assert_wait_silent_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ALN_WAIT) |=> !byte_vld_o);
    // R6: one completion pulse per byte
    assert_byte_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        byte_vld_o |=> !byte_vld_o);
    // R8: a restart always returns to the waiting state
    assert_restart_wait_R8: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (state_q == ALN_WAIT));
endmodule

// File: rtl/adcb_fifo_wr.sv
module adcb_fifo_wr #(
    parameter int BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 restart_i,
    input  logic                 byte_vld_i,
    input  logic [BYTE_BITS-1:0] byte_i,
    input  logic                 fifo_full_i,
    output logic [BYTE_BITS-1:0] fifo_data_o,
    output logic                 fifo_wr_o,
    output logic                 overflow_o
);
    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            fifo_wr_o   <= 1'b0;
            fifo_data_o <= '0;
            overflow_o  <= 1'b0;
        end else begin
            fifo_wr_o <= 1'b0;
            if (byte_vld_i) begin
                if (!fifo_full_i) begin
                    fifo_wr_o   <= 1'b1;
                    fifo_data_o <= byte_i;
                end else begin
                    overflow_o <= 1'b1;
                end
            end
        end
    end

    // R6: a write only follows an edge where the FIFO had room
    assert_wr_gated_R6: assert property (@(posedge clk) disable iff (rst)
        fifo_wr_o |-> !$past(fifo_full_i));
    assert_wr_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        fifo_wr_o |=> !fifo_wr_o);
    // R7: the overflow flag holds until a restart
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(overflow_o) && !$past(restart_i)) |-> overflow_o);
    // R8: restart clears the flag and suppresses writes
    assert_restart_clear_R8: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (!overflow_o && !fifo_wr_o));
endmodule

// File: rtl/audio_adc_fifo_bridge.sv
module audio_adc_fifo_bridge
    import adcb_pkg::*;
#(
    parameter int SAMPLE_BITS = 24,
    parameter int BYTE_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_clk_i,
    input  logic       word_clk_i,
    input  logic       ser_data_i,
    input  logic       host_rx_i,
    input  logic       fifo_full_i,
    output logic [7:0] fifo_data_o,
    output logic       fifo_wr_o,
    output logic       overflow_o
);
    serial_evt_t          evt;
    logic                 byte_vld;
    logic [BYTE_BITS-1:0] byte_w;
    logic [BYTE_BITS-1:0] data_w;

    adcb_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst       (rst),
        .bit_clk_i (bit_clk_i),
        .word_clk_i(word_clk_i),
        .ser_data_i(ser_data_i),
        .evt_o     (evt)
    );

    adcb_framer #(.SAMPLE_BITS(SAMPLE_BITS), .BYTE_BITS(BYTE_BITS)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .restart_i (host_rx_i),
        .evt_i     (evt),
        .byte_vld_o(byte_vld),
        .byte_o    (byte_w)
    );

    adcb_fifo_wr #(.BYTE_BITS(BYTE_BITS)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .restart_i  (host_rx_i),
        .byte_vld_i (byte_vld),
        .byte_i     (byte_w),
        .fifo_full_i(fifo_full_i),
        .fifo_data_o(data_w),
        .fifo_wr_o  (fifo_wr_o),
        .overflow_o (overflow_o)
    );

    assign fifo_data_o = 8'(data_w);
endmodule

// File: tb/audio_adc_fifo_bridge_tb.sv
module audio_adc_fifo_bridge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BCLK_HALF  = 4;
    localparam int SLOT       = 32;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0, rst = 1'b1;
    logic bit_clk = 1'b0, word_clk = 1'b0, ser_data = 1'b0;
    logic host_rx = 1'b0, fifo_full = 1'b0;
    logic [7:0] fifo_data;
    logic fifo_wr, overflow;

    int checks = 0, failures = 0, wr_count = 0;
    logic prev_wr = 1'b0;
    logic [7:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_adc_fifo_bridge u_dut (
        .clk(clk), .rst(rst), .bit_clk_i(bit_clk), .word_clk_i(word_clk),
        .ser_data_i(ser_data), .host_rx_i(host_rx), .fifo_full_i(fifo_full),
        .fifo_data_o(fifo_data), .fifo_wr_o(fifo_wr), .overflow_o(overflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (fifo_wr) begin
                wr_count++;
                check("R6 write while full", {31'd0, fifo_full}, 32'd0);
                check("R6 strobe width", {31'd0, prev_wr}, 32'd0);
                if (exp_q.size() == 0) begin
                    check("R3/R4 unexpected byte", {24'd0, fifo_data}, 32'hFFFF_FFFF);
                end else begin
                    check("R2/R4 byte value", {24'd0, fifo_data}, {24'd0, exp_q.pop_front()});
                end
            end
            prev_wr = fifo_wr;
        end
    end

    task automatic drive_slot(input logic bit_v, input logic lr);
        @(negedge clk);
        bit_clk = 1'b0; ser_data = bit_v; word_clk = lr;
        repeat (BCLK_HALF) @(negedge clk);
        bit_clk = 1'b1;
        repeat (BCLK_HALF - 1) @(negedge clk);
    endtask

    // R5: bits after the 24th are driven to ones and must not appear
    task automatic send_channel(input logic lr, input logic [23:0] smp,
                                input int n_exp, input int restart_bit);
        for (int b = 0; b < 3; b++)
            if (b < n_exp) exp_q.push_back(smp[23 - 8*b -: 8]);
        for (int i = 0; i < SLOT; i++) begin
            if (i == restart_bit) begin
                @(negedge clk); host_rx = 1'b1;
                @(negedge clk); host_rx = 1'b0;
            end
            drive_slot((i < 24) ? smp[23 - i] : 1'b1, lr);
        end
    endtask

    task automatic send_frame(input logic [23:0] l, input logic [23:0] r,
                              input int nl, input int nr, input int rbit);
        send_channel(1'b1, l, nl, rbit);
        send_channel(1'b0, r, nr, -1);
    endtask

    initial begin
        int snap;
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 wr in reset", {31'd0, fifo_wr}, 32'd0);
        check("R1 ovf in reset", {31'd0, overflow}, 32'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 data after reset", {24'd0, fifo_data}, 32'd0);
        check("R1 ovf after reset", {31'd0, overflow}, 32'd0);

        // R3: a right half before any left rise produces nothing
        send_channel(1'b0, 24'hA5C3E1, 0, -1);
        check("R3 silent before left", wr_count, 0);

        // R2, R4: up-counting left across 0x7FFFFF, down-counting right across zero
        for (int f = 0; f < 4; f++)
            send_frame(24'h7FFFFE + 24'(f), 24'h000002 - 24'(f), 3, 3, -1);

        // R7: full FIFO drops a whole frame
        snap = wr_count;
        fifo_full = 1'b1;
        send_frame(24'h123456, 24'hFEDCBA, 0, 0, -1);
        fifo_full = 1'b0;
        check("R7 no writes while full", wr_count, snap);
        check("R7 overflow set", {31'd0, overflow}, 32'd1);
        send_frame(24'h800000, 24'h7FFFFF, 3, 3, -1);
        check("R7 overflow sticky", {31'd0, overflow}, 32'd1);

        // R8: restart mid-left word: only the first byte made it out
        send_frame(24'h4D2C1B, 24'h9E8F70, 1, 0, 10);
        check("R8 overflow cleared", {31'd0, overflow}, 32'd0);
        send_frame(24'h010203, 24'hF0E0D0, 3, 3, -1);
        send_frame(24'hFFFFFF, 24'h000000, 3, 3, -1);

        repeat (40) @(negedge clk);
        check("R4 all bytes received", exp_q.size(), 0);
        check("R4 byte count", wr_count, 6*4 + 6 + 1 + 12);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule